// File: doc/BRIEF.md
# Double-Buffered Four-Channel Copy Engine

This block copies blocks of memory for up to four independent channels over one shared word-wide memory port. Each channel keeps two copies of its transfer description. Software writes the staged copy (source address, destination address, byte count). The live copy belongs to the engine, which advances it as words move. When a channel is already busy, a second start request queues the staged copy. The engine then swaps it into the live copy the moment the running transfer drains, so the channel never goes idle between the two jobs.

A single engine visits the channels in a fixed rotation, one slot per channel. In a slot it does one of three things: it moves one burst of at most 0x800 bytes, it closes a drained transfer, or it passes straight on when the channel is idle. Each channel has sticky completion, error and overrun flags, and one interrupt line ORs the completion and error flags. For testing, a fault countdown can force a channel to stop with an error, and a one-shot mask can swallow the next completion notice.

Top module: `pingpong_dma`

## Requirements
- R1: After reset every channel is idle, nothing is queued, all status flags and `irq` are low, and `mem_req` is low.
- R2: `prg_sel` picks the staged field written by `prg_we`: 0 source, 1 destination, 2 byte count (the two low bits are ignored), and 3 writes nothing. A start on an idle channel copies the staged set into the live set and sets run. The engine then copies the counted bytes one word at a time in ascending order from source to destination. When the live count is zero at the channel's next slot, run falls, the completion flag is set and `irq` rises.
- R3: A start on a running channel only sets the queued flag. When the live transfer drains with the queued flag set, the staged set becomes live, the queued flag clears and run stays high. The queued flag is never high while run is low.
- R4: A staged-field write to a channel whose queued flag is set changes nothing, and it sets that channel's sticky overrun flag.
- R5: A stop clears run and queued together on the next edge. After it, at most the one memory access already in flight completes, no completion flag is set, and no further writes follow.
- R6: A burst moves at most 512 words (0x800 bytes). Slots rotate over channels 0, 1, 2, 3, so a second active channel gets its turn right after the first channel's burst.
- R7: A miss-load command is accepted only with value 1 on a channel that is not running. Any other request pulses `miss_rej` one cycle later. An accepted mask suppresses the completion flag of that channel's next completion only; later completions set it again.
- R8: `fail_load` sets a channel's fault countdown. Each slot of a running channel with a nonzero countdown decrements it. The slot in which it steps from 1 to 0 moves no data: run and queued clear, the error flag is set and `irq` rises.
- R9: `stat_clr` clears the completion, error and overrun flags of each channel whose mask bit is set. `irq` is high exactly when any completion or error flag is set.
- R10: A transfer with a count below one word completes at its first slot with no memory access.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`. `mem_we` is high for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ch | input | CHW | Channel addressed by any command this cycle |
| prg_we | input | 1 | Write one staged field |
| prg_sel | input | 2 | Staged field select (0 src, 1 dst, 2 count) |
| prg_data | input | AW | Staged field value |
| go | input | 1 | Start or queue a transfer |
| halt | input | 1 | Stop the channel and drop any queued transfer |
| miss_load | input | 1 | Request a one-shot completion mask |
| miss_val | input | 2 | Requested mask count (only 1 accepted) |
| miss_rej | output | 1 | Pulse: last miss-load refused |
| fail_load | input | 1 | Load the fault countdown |
| fail_val | input | FW | Fault countdown value |
| stat_clr | input | NCH | Per-channel flag clear mask |
| run_o | output | NCH | Channel running |
| pend_o | output | NCH | Second transfer queued |
| done_o | output | NCH | Sticky completion flags |
| err_o | output | NCH | Sticky error flags |
| ovr_o | output | NCH | Sticky overrun flags |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
A corrupted live register set shows up on the memory port within one slot of the channel's next turn. The port would carry a wrong address, a wrong word count per burst, or a burst placed out of turn. The bench checks all three through destination contents and write counts. A wrong run or queued bit shows up on `run_o` and `pend_o` on the very next edge after a command. A slip in the swap shows up as a gap in run between two queued jobs, or as the second job copying the wrong region. A wrong mask or countdown only becomes visible at the next completion or slot of that channel, so the bench always drives a full transfer through after loading one.

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 13,
  parameter int BURST = 2048,
  parameter int FW    = 4,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] cmd_ch,
  input  logic           prg_we,
  input  logic [1:0]     prg_sel,
  input  logic [AW-1:0]  prg_data,
  input  logic           go,
  input  logic           halt,
  input  logic           miss_load,
  input  logic [1:0]     miss_val,
  output logic           miss_rej,
  input  logic           fail_load,
  input  logic [FW-1:0]  fail_val,
  input  logic [NCH-1:0] stat_clr,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] err_o,
  output logic [NCH-1:0] ovr_o,
  output logic           irq,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  localparam int BB = DW / 8;
  localparam int AB = $clog2(BB);
  localparam int BW = BURST / BB;
  localparam int WW = $clog2(BW + 1);
  localparam int NW = CW - AB;

  typedef enum logic [1:0] {PICK, RD, WR} st_t;

  logic [AW-1:0]  p_src [NCH];
  logic [AW-1:0]  p_dst [NCH];
  logic [CW-1:0]  p_cnt [NCH];
  logic [AW-1:0]  a_src [NCH];
  logic [AW-1:0]  a_dst [NCH];
  logic [CW-1:0]  a_cnt [NCH];
  logic [FW-1:0]  fail_c [NCH];
  logic [NCH-1:0] run, pend, miss, done_s, err_s, ovr_s;
  logic [NCH-1:0] run_n, pend_n, ld, ev_fail, ev_done, adv;
  st_t            st;
  logic [CHW-1:0] cur;
  logic [WW-1:0]  wleft;
  logic           abort;
  logic [DW-1:0]  buf_q;
  logic [AW-1:0]  addr_q;

  wire [NW-1:0]  cur_words = a_cnt[cur][CW-1:AB];
  wire [WW-1:0]  first     = (int'(cur_words) > BW) ? WW'(BW) : WW'(cur_words);
  wire           slot      = (st == PICK) && run[cur];
  wire           failing   = slot && (fail_c[cur] == FW'(1));
  wire           fail_dec  = slot && (fail_c[cur] != '0);
  wire           finish    = slot && !failing && (cur_words == '0);
  wire           start     = slot && !failing && (cur_words != '0);
  wire [CHW-1:0] cur_nx    = (cur == CHW'(NCH - 1)) ? '0 : cur + 1'b1;
  wire           abort_now = abort || ld[cur] || !run_n[cur];

  assign run_o     = run;
  assign pend_o    = pend;
  assign done_o    = done_s;
  assign err_o     = err_s;
  assign ovr_o     = ovr_s;
  assign irq       = |(done_s | err_s);
  assign mem_req   = (st != PICK);
  assign mem_we    = (st == WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = buf_q;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ev_fail[i] = failing && (cur == CHW'(i));
      ev_done[i] = finish && (cur == CHW'(i));
      adv[i]     = (st == WR) && mem_ack && !abort_now && (cur == CHW'(i));
      run_n[i]   = run[i];
      pend_n[i]  = pend[i];
      ld[i]      = 1'b0;
      if (ev_fail[i]) begin
        run_n[i]  = 1'b0;
        pend_n[i] = 1'b0;
      end
      if (ev_done[i]) begin
        if (pend[i]) begin
          ld[i]     = 1'b1;
          pend_n[i] = 1'b0;
        end else begin
          run_n[i] = 1'b0;
        end
      end
      if (halt && cmd_ch == CHW'(i)) begin
        run_n[i]  = 1'b0;
        pend_n[i] = 1'b0;
      end
      if (go && cmd_ch == CHW'(i)) begin
        if (run_n[i]) begin
          pend_n[i] = 1'b1;
        end else begin
          ld[i]    = 1'b1;
          run_n[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; pend <= '0; miss <= '0;
      done_s <= '0; err_s <= '0; ovr_s <= '0;
      miss_rej <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        p_src[i] <= '0; p_dst[i] <= '0; p_cnt[i] <= '0;
        a_src[i] <= '0; a_dst[i] <= '0; a_cnt[i] <= '0;
        fail_c[i] <= '0;
      end
    end else begin
      run  <= run_n;
      pend <= pend_n;
      miss_rej <= miss_load && !(miss_val == 2'd1 && !run[cmd_ch]);
      for (int i = 0; i < NCH; i++) begin
        if (prg_we && cmd_ch == CHW'(i)) begin
          if (pend[i]) ovr_s[i] <= 1'b1;
          else begin
            case (prg_sel)
              2'd0: p_src[i] <= prg_data;
              2'd1: p_dst[i] <= prg_data;
              2'd2: p_cnt[i] <= prg_data[CW-1:0];
              default: ;
            endcase
          end
        end
        if (stat_clr[i] && !(prg_we && cmd_ch == CHW'(i) && pend[i])) ovr_s[i] <= 1'b0;
        done_s[i] <= (done_s[i] && !stat_clr[i]) || (ev_done[i] && !miss[i]);
        err_s[i]  <= (err_s[i] && !stat_clr[i]) || ev_fail[i];
        if (miss_load && cmd_ch == CHW'(i) && miss_val == 2'd1 && !run[i]) miss[i] <= 1'b1;
        else if (ev_done[i]) miss[i] <= 1'b0;
        if (fail_load && cmd_ch == CHW'(i)) fail_c[i] <= fail_val;
        else if (fail_dec && cur == CHW'(i)) fail_c[i] <= fail_c[i] - 1'b1;
        if (ld[i]) begin
          a_src[i] <= p_src[i];
          a_dst[i] <= p_dst[i];
          a_cnt[i] <= p_cnt[i];
        end else if (adv[i]) begin
          a_src[i] <= a_src[i] + AW'(BB);
          a_dst[i] <= a_dst[i] + AW'(BB);
          a_cnt[i] <= a_cnt[i] - CW'(BB);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PICK; cur <= '0; wleft <= '0; abort <= 1'b0;
      buf_q <= '0; addr_q <= '0;
    end else begin
      if (st == PICK) abort <= 1'b0;
      else if (abort_now) abort <= 1'b1;
      case (st)
        PICK: begin
          if (start) begin
            st     <= RD;
            wleft  <= first;
            addr_q <= a_src[cur];
          end else begin
            cur <= cur_nx;
          end
        end
        RD: if (mem_ack) begin
          if (abort_now) begin
            st  <= PICK;
            cur <= cur_nx;
          end else begin
            buf_q  <= mem_rdata;
            addr_q <= a_dst[cur];
            st     <= WR;
          end
        end
        WR: if (mem_ack) begin
          if (abort_now || wleft == WW'(1)) begin
            st  <= PICK;
            cur <= cur_nx;
          end else begin
            wleft  <= wleft - 1'b1;
            addr_q <= a_src[cur] + AW'(BB);
            st     <= RD;
          end
        end
        default: st <= PICK;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CHW-1:0] cmd_ch,
  input logic           prg_we,
  input logic           go,
  input logic           halt,
  input logic           miss_load,
  input logic [1:0]     miss_val,
  input logic           miss_rej,
  input logic [NCH-1:0] run_o,
  input logic [NCH-1:0] pend_o,
  input logic [NCH-1:0] err_o,
  input logic [NCH-1:0] ovr_o,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_PEND_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[i] |-> run_o[i]); // R3
    AST_OVR_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      prg_we && cmd_ch == CHW'(i) && pend_o[i] |=> ovr_o[i]); // R4
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      halt && !go && cmd_ch == CHW'(i) |=> !run_o[i] && !pend_o[i]); // R5
    AST_ERR_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o[i]) |-> $past(run_o[i])); // R8
  end

  AST_MISS_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_load && (miss_val != 2'd1 || run_o[cmd_ch]) |=> miss_rej); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
endmodule

bind pingpong_dma pingpong_dma_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/pingpong_dma_test.sv
module pingpong_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_ch = '0;
  logic        prg_we = 1'b0;
  logic [1:0]  prg_sel = '0;
  logic [31:0] prg_data = '0;
  logic        go = 1'b0, halt = 1'b0;
  logic        miss_load = 1'b0;
  logic [1:0]  miss_val = '0;
  logic        miss_rej;
  logic        fail_load = 1'b0;
  logic [3:0]  fail_val = '0;
  logic [3:0]  stat_clr = '0;
  logic [3:0]  run_o, pend_o, done_o, err_o, ovr_o;
  logic        irq, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int wr_cnt = 0, hs_bad = 0, a_writes = 0, first_b = -1;
  logic [31:0] mem [0:4095];

  always #2.5 clk = ~clk;

  pingpong_dma uut (.*);

  function automatic logic [31:0] pat(input int i);
    return i * 32'h9E3779B1 + 32'h01234567;
  endfunction

  initial begin
    int lat = 0;
    logic [31:0] la = '0;
    logic lwe = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = 0;
      end else if (mem_req) begin
        if (lat == 0) begin
          la = mem_addr; lwe = mem_we; lat = 1;
        end else begin
          if (mem_addr != la || mem_we != lwe) hs_bad++;
          mem_ack = 1'b1;
          lat = 0;
          if (mem_we) begin
            mem[mem_addr[13:2]] = mem_wdata;
            wr_cnt++;
            if (mem_addr >= 32'h3800 && first_b < 0) first_b = a_writes;
            if (mem_addr >= 32'h2000 && mem_addr < 32'h2900) a_writes++;
          end else begin
            mem_rdata = mem[mem_addr[13:2]];
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prg(input int ch, input int sel, input logic [31:0] d);
    cmd_ch = 2'(ch); prg_sel = 2'(sel); prg_data = d; prg_we = 1'b1;
    tick(1);
    prg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    prg(ch, 0, s); prg(ch, 1, d); prg(ch, 2, c);
  endtask

  task automatic go_ch(input int ch);
    cmd_ch = 2'(ch); go = 1'b1;
    tick(1);
    go = 1'b0;
  endtask

  task automatic clr_all();
    stat_clr = 4'hF; tick(1); stat_clr = '0;
  endtask

  task automatic wait_idle(input int ch, input string tag);
    int n = 0;
    while (run_o[ch] && n < 20000) begin tick(1); n++; end
    chk(!run_o[ch], tag, 32'(n), 32'd0);
  endtask

  function automatic int bad_words(input logic [31:0] s, input logic [31:0] d, input int bytes);
    int b = 0;
    for (int k = 0; k < bytes / 4; k++)
      if (mem[(d >> 2) + k] != pat((s >> 2) + k)) b++;
    return b;
  endfunction

  task automatic t_reset();
    chk(run_o == 0 && pend_o == 0, "R1 run/pend", {24'd0, run_o, pend_o}, 0);
    chk(done_o == 0 && err_o == 0 && ovr_o == 0, "R1 status", {20'd0, done_o, err_o, ovr_o}, 0);
    chk(!irq && !mem_req, "R1 irq/req", {30'd0, irq, mem_req}, 0);
  endtask

  task automatic t_single();
    init_mem();
    setup(1, 32'h0100, 32'h2100, 32'h40);
    go_ch(1);
    chk(run_o[1], "R2 run after go", 32'(run_o), 32'h2);
    wait_idle(1, "R2 idle");
    chk(bad_words(32'h0100, 32'h2100, 32'h40) == 0, "R2 copy", 32'(bad_words(32'h0100, 32'h2100, 32'h40)), 0);
    chk(mem[(32'h2140) >> 2] == pat(32'h2140 >> 2), "R2 no overrun of dst", mem[32'h2140 >> 2], pat(32'h2140 >> 2));
    chk(done_o[1] && irq, "R2 done+irq", {30'd0, done_o[1], irq}, 3);
    stat_clr = 4'h2; tick(1); stat_clr = '0;
    chk(!done_o[1] && !irq, "R9 clear", {30'd0, done_o[1], irq}, 0);
  endtask

  task automatic t_queue();
    int n = 0;
    bit gap = 0;
    init_mem();
    clr_all();
    setup(2, 32'h0200, 32'h2200, 32'h100);
    go_ch(2);
    setup(2, 32'h0400, 32'h2400, 32'h80);
    prg(2, 3, 32'h0000_0F00);
    go_ch(2);
    chk(pend_o[2] && run_o[2], "R3 queued", {30'd0, pend_o[2], run_o[2]}, 3);
    prg(2, 0, 32'h0600);
    chk(ovr_o[2], "R4 overrun flag", 32'(ovr_o), 32'h4);
    while (pend_o[2] && n < 20000) begin
      if (!run_o[2]) gap = 1;
      tick(1); n++;
    end
    chk(!gap && run_o[2], "R3 run held across swap", {31'd0, run_o[2]}, 1);
    chk(done_o[2], "R3 first completion", 32'(done_o), 32'h4);
    stat_clr = 4'h4; tick(1); stat_clr = '0;
    wait_idle(2, "R3 idle");
    chk(done_o[2], "R3 second completion", 32'(done_o), 32'h4);
    chk(bad_words(32'h0200, 32'h2200, 32'h100) == 0, "R3 first copy", 32'(bad_words(32'h0200, 32'h2200, 32'h100)), 0);
    chk(bad_words(32'h0400, 32'h2400, 32'h80) == 0, "R4 blocked write ignored", 32'(bad_words(32'h0400, 32'h2400, 32'h80)), 0);
    stat_clr = 4'h4; tick(1); stat_clr = '0;
    chk(!ovr_o[2], "R9 overrun cleared", 32'(ovr_o), 0);
  endtask

  task automatic t_halt();
    int w0;
    init_mem();
    clr_all();
    setup(3, 32'h0800, 32'h2800, 32'h800);
    go_ch(3);
    tick(100);
    go_ch(3);
    chk(pend_o[3], "R5 queued before stop", 32'(pend_o), 32'h8);
    cmd_ch = 2'd3; halt = 1'b1; tick(1); halt = 1'b0;
    chk(!run_o[3] && !pend_o[3], "R5 stop clears both", {30'd0, run_o[3], pend_o[3]}, 0);
    tick(4);
    w0 = wr_cnt;
    tick(60);
    chk(wr_cnt == w0, "R5 no writes after stop", 32'(wr_cnt), 32'(w0));
    chk(!done_o[3], "R5 no completion", 32'(done_o), 0);
  endtask

  task automatic t_burst();
    init_mem();
    clr_all();
    a_writes = 0; first_b = -1;
    setup(0, 32'h0000, 32'h2000, 32'h900);
    setup(1, 32'h1000, 32'h3800, 32'h40);
    go_ch(0);
    tick(20);
    go_ch(1);
    wait_idle(0, "R6 idle ch0");
    wait_idle(1, "R6 idle ch1");
    chk(first_b == 512, "R6 burst limit and rotation", 32'(first_b), 32'd512);
    chk(a_writes == 576, "R6 total words ch0", 32'(a_writes), 32'd576);
    chk(bad_words(32'h0000, 32'h2000, 32'h900) == 0, "R6 copy ch0", 32'(bad_words(32'h0000, 32'h2000, 32'h900)), 0);
    chk(bad_words(32'h1000, 32'h3800, 32'h40) == 0, "R6 copy ch1", 32'(bad_words(32'h1000, 32'h3800, 32'h40)), 0);
  endtask

  task automatic t_miss();
    init_mem();
    clr_all();
    cmd_ch = 2'd2; miss_val = 2'd2; miss_load = 1'b1; tick(1); miss_load = 1'b0;
    chk(miss_rej, "R7 value 2 refused", {31'd0, miss_rej}, 1);
    cmd_ch = 2'd2; miss_val = 2'd1; miss_load = 1'b1; tick(1); miss_load = 1'b0;
    chk(!miss_rej, "R7 value 1 accepted", {31'd0, miss_rej}, 0);
    setup(2, 32'h0300, 32'h2300, 32'h20);
    go_ch(2);
    wait_idle(2, "R7 idle");
    chk(!done_o[2] && !irq, "R7 completion masked", {30'd0, done_o[2], irq}, 0);
    chk(bad_words(32'h0300, 32'h2300, 32'h20) == 0, "R7 copy still done", 32'(bad_words(32'h0300, 32'h2300, 32'h20)), 0);
    go_ch(2);
    wait_idle(2, "R7 idle 2");
    chk(done_o[2], "R7 mask is one-shot", 32'(done_o), 32'h4);
    clr_all();
    setup(2, 32'h0300, 32'h2300, 32'h200);
    go_ch(2);
    cmd_ch = 2'd2; miss_val = 2'd1; miss_load = 1'b1; tick(1); miss_load = 1'b0;
    chk(miss_rej, "R7 refused while running", {31'd0, miss_rej}, 1);
    wait_idle(2, "R7 idle 3");
    chk(done_o[2], "R7 refused mask has no effect", 32'(done_o), 32'h4);
  endtask

  task automatic t_fail();
    int w0;
    init_mem();
    clr_all();
    w0 = wr_cnt;
    cmd_ch = 2'd1; fail_val = 4'd1; fail_load = 1'b1; tick(1); fail_load = 1'b0;
    setup(1, 32'h0100, 32'h2100, 32'h40);
    go_ch(1);
    wait_idle(1, "R8 idle");
    chk(err_o[1] && irq && !done_o[1], "R8 error flag", {29'd0, err_o[1], irq, done_o[1]}, 6);
    chk(wr_cnt == w0, "R8 no data moved", 32'(wr_cnt), 32'(w0));
    stat_clr = 4'h2; tick(1); stat_clr = '0;
    chk(!err_o[1] && !irq, "R9 error cleared", {30'd0, err_o[1], irq}, 0);
  endtask

  task automatic t_zero();
    int w0;
    clr_all();
    w0 = wr_cnt;
    setup(0, 32'h0000, 32'h2000, 32'h3);
    go_ch(0);
    wait_idle(0, "R10 idle");
    chk(done_o[0], "R10 completes", 32'(done_o), 32'h1);
    chk(wr_cnt == w0, "R10 no access", 32'(wr_cnt), 32'(w0));
    chk(hs_bad == 0, "R11 request stable until ack", 32'(hs_bad), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_single();
    t_queue();
    t_halt();
    t_burst();
    t_miss();
    t_fail();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule